// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is one timer channel working in waveform generation mode. A single up-counter, advanced by a selectable tick, restarts automatically when it reaches the period compare value. Two pulse outputs, A and B, share that period. Each output has its own duty compare value. Each output's edges come from programmable set/clear actions. An action can be tied to the output's own compare match, to the shared period match, or to a software trigger.

Software programs the channel through a simple write port. The registers are a mode word, three compare values and a control word. The control word starts or stops the counter clock and can issue a software trigger. A trigger restarts the count from zero and forces each output to its programmed trigger level. If an output has no compare actions, it keeps its trigger level indefinitely. This gives a steady 0% or 100% duty cycle. The counter width is a parameter (16 or 32 bits).

Top module: `wave_timer_chan`

## Requirements
- R1: After reset the counter clock is stopped, the count is zero, both outputs are low and every action field reads as "no action", so a software trigger alone leaves both outputs low.
- R2: Mode bits [2:0] choose the tick. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 input clocks. After a trigger at edge E0, ticks fall on edges E0+D·k for k ≥ 1.
- R3: Mode select value 4 takes one tick per cycle in which `slow_tick` is high while the clock is enabled. Without such pulses the count does not move.
- R4: On each tick the counter increments, except that a tick seen while the count equals the period value returns it to zero. The period is therefore (period value + 1) ticks.
- R5: The action codes are 2'b01 = set, 2'b10 = clear, 2'b00 and 2'b11 = no action. The mode fields are: A on its compare match [4:3], A on the period match [6:5], A on the trigger [8:7], B on its compare match [10:9], B on the period match [12:11], B on the trigger [14:13].
- R6: A control write with bit 2 set restarts the prescaler and the counter at zero. One edge later, it applies each output's trigger action.
- R7: Control bit 0 starts the counter clock and bit 1 stops it; if both are set, stop wins. Trigger plus stop leaves both outputs at their trigger levels with no further edges.
- R8: An output whose compare and period actions are both "no action" holds its last level.
- R9: When several events with programmed actions reach one output together, the trigger wins over the period match, and the period match wins over the output's own compare match.
- R10: A match seen on a tick edge is registered at that edge. The output changes at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | Slow-clock tick, one cycle per slow period, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 mode, 1 compare A, 2 compare B, 3 period, 4 control |
| wr_data | input | CW | Write data |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
The embedded assertions check several rules on every cycle. They check that stop wins over start, that no tick occurs while the clock is stopped, that the count returns to zero after a tick at the period value, and that a match flag only follows a tick. They also check trigger-over-period and period-over-compare priority, and that an output holds when no event reaches it. Only the bench scenarios can show the cycle-exact waveforms: the position of every edge for each prescale choice, the slow-tick stepping, the decoding of the action fields, and the frozen and constant-level cases.

// File: rtl/wtc_pkg.sv
// Package: shared types and constants for the waveform timer channel.
// Assumes the data word is at least MODE_W bits wide.
package wtc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_RSVD = 2'b11
    } act_e;

    // Mode word, LSB first: csel, A compare, A period, A trigger, B compare, B period, B trigger
    typedef struct packed {
        act_e       b_sw;
        act_e       b_rc;
        act_e       b_cmp;
        act_e       a_sw;
        act_e       a_rc;
        act_e       a_cmp;
        logic [2:0] csel;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam logic [2:0] ADR_MODE = 3'd0;
    localparam logic [2:0] ADR_CMPA = 3'd1;
    localparam logic [2:0] ADR_CMPB = 3'd2;
    localparam logic [2:0] ADR_PER  = 3'd3;
    localparam logic [2:0] ADR_CTL  = 3'd4;

    localparam int CTL_EN  = 0;
    localparam int CTL_DIS = 1;
    localparam int CTL_SW  = 2;

    localparam logic [2:0] CSEL_SLOW = 3'd4;

    // True when the code requests a level change
    function automatic logic act_live(act_e a);
        return (a == ACT_SET) || (a == ACT_CLR);
    endfunction

endpackage

// File: rtl/wtc_regs.sv
// Register file: holds the mode word, compares and clock-run state.
// Decodes control writes into a restart strobe and a registered trigger pulse.
// Assumes CW >= MODE_W.
module wtc_regs #(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [CW-1:0]        wr_data,
    output wtc_pkg::mode_t       mode,
    output logic [CW-1:0]        cmp_a,
    output logic [CW-1:0]        cmp_b,
    output logic [CW-1:0]        per,
    output logic                 clk_on,
    output logic                 restart,
    output logic                 sw_pend
);
    import wtc_pkg::*;

    logic ctl_wr;

    // Decode a control-word write
    assign ctl_wr  = wr_en && (wr_addr == ADR_CTL);
    // A trigger restarts prescaler and counter at the write edge
    assign restart = ctl_wr && wr_data[CTL_SW];

    // Capture configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
            per   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_MODE: mode  <= mode_t'(wr_data[MODE_W-1:0]);
                ADR_CMPA: cmp_a <= wr_data;
                ADR_CMPB: cmp_b <= wr_data;
                ADR_PER:  per   <= wr_data;
                default:  ;
            endcase
        end
    end

    // Run state: stop has priority over start
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_on <= 1'b0;
        else if (ctl_wr && wr_data[CTL_DIS])
            clk_on <= 1'b0;
        else if (ctl_wr && wr_data[CTL_EN])
            clk_on <= 1'b1;
    end

    // Trigger pulse reaches the outputs one edge after the write
    always_ff @(posedge clk) begin
        if (!rst_n) sw_pend <= 1'b0;
        else        sw_pend <= restart;
    end

    // R7
    ctl_dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[CTL_DIS]) |=> !clk_on);

    // R6
    sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pend |-> $past(wr_en && (wr_addr == ADR_CTL) && wr_data[CTL_SW]));

endmodule

// File: rtl/wtc_prescale.sv
// Prescaler: produces the count-enable tick from the input clock
// (divide by 2/8/32/128) or from the slow tick input.
// Assumes slow_tick is already synchronous to clk.
module wtc_prescale #(
    parameter int PW = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_on,
    input  logic       restart,
    input  logic [2:0] csel,
    input  logic       slow_tick,
    output logic       tick
);
    import wtc_pkg::*;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] last;
    logic          fast;

    // Terminal value of the divider for each fast selection
    always_comb begin
        fast = 1'b1;
        case (csel)
            3'd0:    last = PW'(1);
            3'd1:    last = PW'(7);
            3'd2:    last = PW'(31);
            3'd3:    last = PW'(127);
            default: begin last = '0; fast = 1'b0; end
        endcase
    end

    // Tick selection; a restart suppresses a coincident tick
    always_comb begin
        if (!clk_on || restart)
            tick = 1'b0;
        else if (fast)
            tick = (pcnt == last);
        else
            tick = (csel == CSEL_SLOW) && slow_tick;
    end

    // Divider phase counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (restart || !clk_on || !fast || (pcnt == last))
            pcnt <= '0;
        else
            pcnt <= pcnt + PW'(1);
    end

    // R7
    tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_on |-> !tick);

    // R3
    slow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (csel == CSEL_SLOW)) |-> slow_tick);

endmodule

// File: rtl/wtc_counter.sv
// Up-counter with automatic restart on the period compare and
// registered match flags for both duty compares and the period.
// Assumes compares are stable while the clock runs.
module wtc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic [CW-1:0] cmp_a,
    input  logic [CW-1:0] cmp_b,
    input  logic [CW-1:0] per,
    output logic [1:0]    hit_cmp,
    output logic          hit_per
);
    logic [CW-1:0] cnt;

    // Count, returning to zero on the period value or a restart
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == per) ? '0 : cnt + CW'(1);
    end

    // Register compare results seen on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cmp <= '0;
            hit_per <= 1'b0;
        end else begin
            hit_cmp <= {tick && (cnt == cmp_b), tick && (cnt == cmp_a)};
            hit_per <= tick && (cnt == per);
        end
    end

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == per)) |=> (cnt == '0));

    // R10
    hit_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_per || (hit_cmp != 2'b00)) |-> $past(tick));

endmodule

// File: rtl/wtc_outstage.sv
// Output flip-flop: applies trigger, period and compare actions with
// priority trigger > period > compare; codes without a level are skipped.
module wtc_outstage (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_pend,
    input  logic          hit_per,
    input  logic          hit_cmp,
    input  wtc_pkg::act_e act_sw,
    input  wtc_pkg::act_e act_per,
    input  wtc_pkg::act_e act_cmp,
    output logic          q
);
    import wtc_pkg::*;

    logic nxt;

    // Later assignments override earlier ones, giving the priority order
    always_comb begin
        nxt = q;
        if (hit_cmp && act_live(act_cmp)) nxt = (act_cmp == ACT_SET);
        if (hit_per && act_live(act_per)) nxt = (act_per == ACT_SET);
        if (sw_pend && act_live(act_sw))  nxt = (act_sw  == ACT_SET);
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end

    // R9
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pend && (act_sw == ACT_SET)) |=> q);

    // R9
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pend && (act_sw == ACT_CLR)) |=> !q);

    // R9
    per_over_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_pend && hit_per && (act_per == ACT_CLR)) |=> !q);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_pend && !hit_per && !hit_cmp) |=> $stable(q));

endmodule

// File: rtl/wave_timer_chan.sv
// Top: one waveform timer channel with two outputs sharing a period.
// Wires the register file, prescaler, counter and two output stages.
// Assumes CW is 16 or 32.
module wave_timer_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          out_a,
    output logic          out_b
);
    import wtc_pkg::*;

    localparam int NOUT = 2;
    localparam int PW   = 7;

    mode_t         mode;
    logic [CW-1:0] cmp_a, cmp_b, per;
    logic          clk_on, restart, sw_pend, tick, hit_per;
    logic [1:0]    hit_cmp;
    act_e          act_sw  [NOUT];
    act_e          act_per [NOUT];
    act_e          act_cmp [NOUT];
    logic [NOUT-1:0] q;

    wtc_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .per(per), .clk_on(clk_on), .restart(restart), .sw_pend(sw_pend)
    );

    wtc_prescale #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .clk_on(clk_on), .restart(restart),
        .csel(mode.csel), .slow_tick(slow_tick), .tick(tick)
    );

    wtc_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .per(per),
        .hit_cmp(hit_cmp), .hit_per(hit_per)
    );

    // Route each output's action fields
    assign act_sw[0]  = mode.a_sw;
    assign act_per[0] = mode.a_rc;
    assign act_cmp[0] = mode.a_cmp;
    assign act_sw[1]  = mode.b_sw;
    assign act_per[1] = mode.b_rc;
    assign act_cmp[1] = mode.b_cmp;

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        wtc_outstage u_out (
            .clk(clk), .rst_n(rst_n), .sw_pend(sw_pend), .hit_per(hit_per),
            .hit_cmp(hit_cmp[i]), .act_sw(act_sw[i]), .act_per(act_per[i]),
            .act_cmp(act_cmp[i]), .q(q[i])
        );
    end

    assign out_a = q[0];
    assign out_b = q[1];

endmodule

// File: tb/sim_wave_timer_chan.sv
module sim_wave_timer_chan;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slow_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          out_a, out_b;

    int checks = 0;
    int errors = 0;
    int gcyc = 0;
    int last_edge = 0;

    typedef struct {
        int    cyc;
        logic  a;
        logic  b;
        string tag;
    } item_t;
    item_t sbq[$];

    wave_timer_chan #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b)
    );

    always #5 clk = ~clk;
    always @(posedge clk) gcyc <= gcyc + 1;

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Monitor: pop expected items when their cycle arrives
    always @(negedge clk) begin
        if (sbq.size() > 0 && sbq[0].cyc == gcyc) begin
            check({sbq[0].tag, " out_a"}, out_a, sbq[0].a);
            check({sbq[0].tag, " out_b"}, out_b, sbq[0].b);
            void'(sbq.pop_front());
        end
    end

    task automatic wr(logic [2:0] adr, logic [CW-1:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = adr; wr_data = dat;
        @(posedge clk);
        #1;
        last_edge = gcyc;
        wr_en = 1'b0;
    endtask

    function automatic logic [CW-1:0] mk_mode(int csel, int ac, int arc, int asw,
                                              int bc, int brc, int bsw);
        logic [CW-1:0] m = '0;
        m[2:0] = 3'(csel); m[4:3] = 2'(ac); m[6:5] = 2'(arc); m[8:7] = 2'(asw);
        m[10:9] = 2'(bc); m[12:11] = 2'(brc); m[14:13] = 2'(bsw);
        return m;
    endfunction

    function automatic bit live(logic [1:0] c);
        return (c == 2'b01) || (c == 2'b10);
    endfunction

    // Expected level n edges after the trigger edge, from the requirements
    function automatic logic model(int n, int d, int cv, int pv, logic [1:0] ac,
                                   logic [1:0] apc, logic [1:0] asw, logic prev);
        logic l = prev;
        if (n >= 1 && live(asw)) l = (asw == 2'b01);
        if (d > 0) begin
            for (int k = 1; d * k + 1 <= n; k++) begin
                int c = (k - 1) % (pv + 1);
                if (c == pv && live(apc)) l = (apc == 2'b01);
                else if (c == cv && live(ac)) l = (ac == 2'b01);
            end
        end
        return l;
    endfunction

    task automatic run_case(int ra, int rb, int rc, logic [CW-1:0] m,
                            logic [CW-1:0] ctl, int ncyc, string tag);
        logic pa, pb;
        int d, e0;
        wr(3'd4, 16'h0002);
        repeat (3) @(negedge clk);
        pa = out_a; pb = out_b;
        wr(3'd0, m); wr(3'd1, CW'(ra)); wr(3'd2, CW'(rb)); wr(3'd3, CW'(rc));
        wr(3'd4, ctl);
        e0 = last_edge;
        case (m[2:0])
            3'd0: d = 2;
            3'd1: d = 8;
            3'd2: d = 32;
            3'd3: d = 128;
            default: d = 0;
        endcase
        if (!ctl[0] || ctl[1]) d = 0;
        for (int n = 1; n <= ncyc; n++) begin
            item_t it;
            it.cyc = e0 + n;
            it.a = model(n, d, ra, rc, m[4:3], m[6:5], m[8:7], pa);
            it.b = model(n, d, rb, rc, m[10:9], m[12:11], m[14:13], pb);
            it.tag = tag;
            sbq.push_back(it);
        end
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic slow_pulse;
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset levels, then a trigger with cleared action fields
        check("R1 reset out_a", out_a, 1'b0);
        check("R1 reset out_b", out_b, 1'b0);
        wr(3'd4, 16'h0004);
        repeat (10) @(negedge clk);
        check("R1 trigger with no action out_a", out_a, 1'b0);
        check("R1 trigger with no action out_b", out_b, 1'b0);

        // R2 R4 R5 R6 R10: divide by 2, opposite actions on A and B
        run_case(2, 4, 5, mk_mode(0, 2, 1, 1, 1, 2, 2), 16'h0005, 40,
                 "R2 R4 R5 R6 R10 div2");
        // R2 R5: divide by 8
        run_case(1, 2, 3, mk_mode(1, 1, 2, 2, 1, 2, 2), 16'h0005, 80,
                 "R2 R5 div8");
        // R2 R4: divide by 32
        run_case(0, 1, 1, mk_mode(2, 2, 1, 1, 1, 0, 2), 16'h0005, 160,
                 "R2 R4 div32");
        // R2: divide by 128
        run_case(0, 0, 1, mk_mode(3, 2, 1, 1, 1, 2, 2), 16'h0005, 530,
                 "R2 div128");
        // R8 R5: no compare actions, including reserved code 2'b11
        run_case(1, 1, 2, mk_mode(0, 0, 0, 1, 3, 3, 2), 16'h0005, 40,
                 "R8 R5 constant level");
        // R9: A compare and period on the same count, period wins
        run_case(2, 2, 2, mk_mode(0, 1, 2, 2, 2, 0, 1), 16'h0005, 40,
                 "R9 period over compare");
        // R7: trigger with stop freezes trigger levels
        run_case(2, 4, 5, mk_mode(0, 2, 1, 1, 1, 2, 2), 16'h0006, 60,
                 "R7 trigger with stop");
        // R7: start and stop together, stop wins
        run_case(2, 4, 5, mk_mode(0, 2, 1, 2, 1, 2, 1), 16'h0007, 60,
                 "R7 stop wins over start");
        // R6: restart from a stopped mid-period count
        run_case(2, 4, 5, mk_mode(0, 2, 1, 1, 1, 2, 2), 16'h0005, 15,
                 "R6 partial run");
        run_case(2, 4, 5, mk_mode(0, 2, 1, 1, 1, 2, 2), 16'h0005, 40,
                 "R6 restart at zero");

        // R3: slow tick source
        wr(3'd4, 16'h0002);
        wr(3'd0, mk_mode(4, 2, 1, 1, 0, 0, 0));
        wr(3'd1, 16'd1);
        wr(3'd3, 16'd2);
        wr(3'd4, 16'h0005);
        repeat (20) @(negedge clk);
        check("R3 no slow pulse", out_a, 1'b1);
        slow_pulse();
        check("R3 slow pulse 1 count0", out_a, 1'b1);
        slow_pulse();
        check("R3 slow pulse 2 compare", out_a, 1'b0);
        repeat (10) @(negedge clk);
        check("R3 hold between pulses", out_a, 1'b0);
        slow_pulse();
        check("R3 slow pulse 3 period", out_a, 1'b1);
        slow_pulse();
        check("R3 slow pulse 4 wrapped", out_a, 1'b1);
        slow_pulse();
        check("R3 slow pulse 5 compare", out_a, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule